// File: doc/BRIEF.md
# Almost-Full Status Bus Sharer

This block puts the almost-full state of up to 32 queues onto an 8-line status bus. The queues are grouped eight at a time: group g covers queues 8g to 8g+7. The bus shows one group at a time, and a tag output names the group that is on the bus. A mode input is captured while master reset is held. In address-strobed mode, the host chooses the group by pulsing a strobe together with a write address. In self-cycling mode, the block steps through the configured groups on its own, one group per clock, and ignores the address and the strobe.

When eight or fewer queues are configured, only one group exists. The tag then stays at 0 and each configured queue keeps its own bus line. Bits of the bus that belong to queues beyond the configured count always read 0. The status bus and the tag are plain status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure to honour.

Top module: `afq_bus_share`

## Requirements
- R1: While `rst_n` is low, and after it is released, the tag is 0 until the first active clock edge.
- R2: `flag_mode` is sampled only on clock edges while `rst_n` is low (1 = self-cycling, 0 = address-strobed). A change of `flag_mode` after release has no effect until the next reset.
- R3: In self-cycling mode, the tag advances by one on each rising clock edge. It returns to 0 on the edge after it reaches the last configured group.
- R4: In self-cycling mode, `af_strobe` and `wr_addr` have no effect on the tag.
- R5: In address-strobed mode, a rising edge with `af_strobe` high loads the tag from `wr_addr[4:3]`. With the strobe low, the tag holds.
- R6: In address-strobed mode, a strobe whose `wr_addr[4:3]` names a group at or beyond the number of configured groups leaves the tag unchanged.
- R7: Bus bit k equals `af_vec[8*tag+k]` when queue 8*tag+k is below `q_count`; otherwise bit k is 0.
- R8: With `q_count` of 8 or less, the tag stays 0 in both modes, and bus bit k shows queue k for each configured queue.
- R9: The number of configured groups is ceil(`q_count`/8), with a minimum of one group. With `q_count` = 0, the whole bus reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| flag_mode | input | 1 | Sharing mode, captured during reset: 1 self-cycling, 0 address-strobed |
| q_count | input | 6 | Number of configured queues (0 to 32), static outside reset |
| af_vec | input | 32 | Per-queue almost-full state, bit i for queue i, 1 = almost full |
| wr_addr | input | 8 | Write address; bits [4:3] pick the group in address-strobed mode |
| af_strobe | input | 1 | Group-select strobe for address-strobed mode |
| af_bus | output | 8 | Almost-full state of the group on the bus |
| grp_tag | output | 2 | Index of the group currently on the bus |

## Verification
The bench targets the wrap point of the self-cycling counter at group counts that do not fill the tag range (20 and 9 queues). A design that wraps on the tag width instead of the configured count would show empty or stale groups there. It strobes groups beyond the configured range in address-strobed mode; a design that loaded them anyway would put an all-zero group on the bus. It flips the mode pin after reset and drives the strobe while in self-cycling mode, which would reveal a design that resamples the mode or lets the address steer the counter. Partially populated groups and the 0-, 5- and 8-queue cases check that unconfigured lines read 0 and that dedicated lines never move.

// File: rtl/afq_pkg.sv
package afq_pkg;
  typedef enum logic {
    SHARE_STROBED = 1'b0,
    SHARE_CYCLING = 1'b1
  } share_mode_e;
endpackage

// File: rtl/afq_mode_latch.sv
module afq_mode_latch
  import afq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_in,
  output share_mode_e mode_q
);
  // Mode is taken only while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= share_mode_e'(mode_in);
  end
endmodule

// File: rtl/afq_span_calc.sv
module afq_span_calc #(
  parameter int LANES  = 8,
  parameter int GROUPS = 4,
  parameter int GRP_W  = 2,
  parameter int QCNT_W = 6
) (
  input  logic [QCNT_W-1:0] q_count,
  output logic [GRP_W-1:0]  grp_last
);
  int need;
  // R9: ceil(q_count / LANES), clamped to [1, GROUPS]
  always_comb begin
    need = (int'(q_count) + LANES - 1) / LANES;
    if (need > GROUPS) need = GROUPS;
    if (need < 1) need = 1;
    grp_last = GRP_W'(need - 1);
  end
endmodule

// File: rtl/afq_group_seq.sv
module afq_group_seq
  import afq_pkg::*;
#(
  parameter int GRP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  share_mode_e      mode,
  input  logic [GRP_W-1:0] grp_last,
  input  logic             strobe,
  input  logic [GRP_W-1:0] addr_grp,
  output logic [GRP_W-1:0] grp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp <= '0;
    end else if (mode == SHARE_CYCLING) begin
      grp <= (grp >= grp_last) ? '0 : grp + GRP_W'(1);
    end else if (strobe && (addr_grp <= grp_last)) begin
      grp <= addr_grp;
    end
  end
endmodule

// File: rtl/afq_lane_pick.sv
module afq_lane_pick #(
  parameter int QMAX   = 32,
  parameter int LANES  = 8,
  parameter int GRP_W  = 2,
  parameter int QCNT_W = 6
) (
  input  logic [QMAX-1:0]   af_vec,
  input  logic [QCNT_W-1:0] q_count,
  input  logic [GRP_W-1:0]  grp,
  output logic [LANES-1:0]  lanes
);
  localparam int QIDX_W = $clog2(QMAX);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [31:0] qidx;
    assign qidx     = 32'(grp) * 32'(LANES) + 32'(k);
    assign lanes[k] = (qidx < 32'(QMAX)) && (qidx < 32'(q_count))
                      && af_vec[qidx[QIDX_W-1:0]];
  end
endmodule

// File: rtl/afq_bus_share.sv
module afq_bus_share
  import afq_pkg::*;
#(
  parameter int QMAX   = 32,
  parameter int LANES  = 8,
  parameter int ADDR_W = 8,
  localparam int GROUPS = QMAX / LANES,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int LANE_W = $clog2(LANES),
  localparam int QCNT_W = $clog2(QMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_mode,
  input  logic [QCNT_W-1:0] q_count,
  input  logic [QMAX-1:0]   af_vec,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              af_strobe,
  output logic [LANES-1:0]  af_bus,
  output logic [GRP_W-1:0]  grp_tag
);
  share_mode_e      share_mode;
  logic [GRP_W-1:0] grp_last;
  logic [GRP_W-1:0] addr_grp;
  logic             unused_addr_bits;

  assign addr_grp         = wr_addr[LANE_W +: GRP_W];
  assign unused_addr_bits = ^wr_addr;

  afq_mode_latch u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_in (flag_mode),
    .mode_q  (share_mode)
  );

  afq_span_calc #(
    .LANES (LANES), .GROUPS (GROUPS), .GRP_W (GRP_W), .QCNT_W (QCNT_W)
  ) u_span (
    .q_count  (q_count),
    .grp_last (grp_last)
  );

  afq_group_seq #(.GRP_W (GRP_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (share_mode),
    .grp_last (grp_last),
    .strobe   (af_strobe),
    .addr_grp (addr_grp),
    .grp      (grp_tag)
  );

  afq_lane_pick #(
    .QMAX (QMAX), .LANES (LANES), .GRP_W (GRP_W), .QCNT_W (QCNT_W)
  ) u_pick (
    .af_vec  (af_vec),
    .q_count (q_count),
    .grp     (grp_tag),
    .lanes   (af_bus)
  );
endmodule

// File: rtl/afq_bus_share_chk.sv
module afq_bus_share_chk
  import afq_pkg::*;
#(
  parameter int QMAX   = 32,
  parameter int LANES  = 8,
  parameter int ADDR_W = 8,
  parameter int GRP_W  = 2,
  parameter int QCNT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input share_mode_e       mode_q,
  input logic [QCNT_W-1:0] q_count,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              strobe,
  input logic [GRP_W-1:0]  grp,
  input logic [LANES-1:0]  bus
);
  localparam int LANE_W = $clog2(LANES);
  localparam int GROUPS = QMAX / LANES;

  int               ngrp;
  logic [GRP_W-1:0] last;
  logic [GRP_W-1:0] a_grp;
  logic [LANES-1:0] cfg_mask;

  always_comb begin
    ngrp = (int'(q_count) + LANES - 1) / LANES;
    if (ngrp > GROUPS) ngrp = GROUPS;
    if (ngrp < 1) ngrp = 1;
    last = GRP_W'(ngrp - 1);
  end
  assign a_grp = wr_addr[LANE_W +: GRP_W];

  for (genvar k = 0; k < LANES; k++) begin : g_m
    assign cfg_mask[k] = (32'(grp) * 32'(LANES) + 32'(k)) < 32'(q_count);
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q)); // R2
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SHARE_CYCLING && grp < last) |=> grp == $past(grp) + GRP_W'(1)); // R3
  AST_CYCLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SHARE_CYCLING && grp >= last) |=> grp == '0); // R3
  AST_STROBE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SHARE_STROBED && strobe && a_grp <= last) |=> grp == $past(a_grp)); // R5
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SHARE_STROBED && !strobe) |=> $stable(grp)); // R5
  AST_RANGE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SHARE_STROBED && strobe && a_grp > last) |=> $stable(grp)); // R6
  AST_UNCFG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus & ~cfg_mask) == '0); // R7
  AST_TAG_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    grp <= last); // R9
endmodule

bind afq_bus_share afq_bus_share_chk #(
  .QMAX (QMAX), .LANES (LANES), .ADDR_W (ADDR_W), .GRP_W (GRP_W), .QCNT_W (QCNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_q  (share_mode),
  .q_count (q_count),
  .wr_addr (wr_addr),
  .strobe  (af_strobe),
  .grp     (grp_tag),
  .bus     (af_bus)
);

// File: tb/sim_afq_bus_share.sv
module sim_afq_bus_share;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  // {strobe, addr, af_vec, exp_tag, exp_bus}; address-strobed mode, 32 queues
  localparam logic [50:0] VEC [NVEC] = '{
    {1'b1, 8'h18, 32'h44332211, 2'd3, 8'h44},  // R5 load group 3
    {1'b0, 8'h00, 32'h44332211, 2'd3, 8'h44},  // R5 hold
    {1'b1, 8'h08, 32'h8899AABB, 2'd1, 8'hAA},  // R5 group 1
    {1'b1, 8'hF0, 32'h0F1E2D3C, 2'd2, 8'h1E},  // R5 upper addr bits ignored
    {1'b1, 8'h07, 32'h000000FF, 2'd0, 8'hFF},  // R5 group 0
    {1'b0, 8'h1F, 32'hFFFFFF00, 2'd0, 8'h00}   // R5 hold, R7 bus follows af_vec
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flag_mode = 1'b0;
  logic [5:0]  q_count = 6'd32;
  logic [31:0] af_vec = '0;
  logic [7:0]  wr_addr = '0;
  logic        af_strobe = 1'b0;
  logic [7:0]  af_bus;
  logic [1:0]  grp_tag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  afq_bus_share u0 (
    .clk (clk), .rst_n (rst_n), .flag_mode (flag_mode), .q_count (q_count),
    .af_vec (af_vec), .wr_addr (wr_addr), .af_strobe (af_strobe),
    .af_bus (af_bus), .grp_tag (grp_tag)
  );

  task automatic cmp(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic mode, input logic [5:0] qc);
    @(negedge clk);
    rst_n = 1'b0; flag_mode = mode; q_count = qc; af_strobe = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic strobe_to(input logic [7:0] addr);
    @(negedge clk);
    af_strobe = 1'b1; wr_addr = addr;
    step();
  endtask

  initial begin
    // R1: state while reset is held
    af_vec = 32'hDEADBEEF;
    repeat (2) @(negedge clk);
    cmp("R1 tag in reset", 32'(grp_tag), 0);
    cmp("R1 bus in reset", 32'(af_bus), 32'hEF);
    rst_n = 1'b1;
    #1;
    cmp("R1 tag after release", 32'(grp_tag), 0);

    // Table walk, address-strobed mode
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      af_strobe = VEC[i][50];
      wr_addr   = VEC[i][49:42];
      af_vec    = VEC[i][41:10];
      step();
      cmp("R5 table tag", 32'(grp_tag), 32'(VEC[i][9:8]));
      cmp("R7 table bus", 32'(af_bus), 32'(VEC[i][7:0]));
    end
    @(negedge clk); af_strobe = 1'b0;

    // R2, R3: self-cycling, mode pin flipped after release
    af_vec = 32'h04030201;
    do_reset(1'b1, 6'd32);
    flag_mode = 1'b0;
    for (int e = 1; e <= 6; e++) begin
      step();
      cmp("R3 cycle tag", 32'(grp_tag), 32'(e % 4));
      cmp("R7 cycle bus", 32'(af_bus), 32'((e % 4) + 1));
    end
    cmp("R2 mode kept", 32'(grp_tag), 2);

    // R4: strobe and address ignored while cycling
    strobe_to(8'h00);
    cmp("R4 strobe ignored", 32'(grp_tag), 3);
    strobe_to(8'h18);
    cmp("R4 wrap despite addr", 32'(grp_tag), 0);
    @(negedge clk); af_strobe = 1'b0;

    // R3, R7: 20 queues -> 3 groups, partial last group
    af_vec = 32'hFFFFFFFF;
    do_reset(1'b1, 6'd20);
    step(); cmp("R3 q20 tag", 32'(grp_tag), 1); cmp("R7 q20 full grp", 32'(af_bus), 32'hFF);
    step(); cmp("R3 q20 tag", 32'(grp_tag), 2); cmp("R7 q20 partial", 32'(af_bus), 32'h0F);
    step(); cmp("R3 q20 wrap", 32'(grp_tag), 0);
    step(); cmp("R3 q20 tag", 32'(grp_tag), 1);

    // R6: 16 queues -> 2 groups, out-of-range strobes ignored
    af_vec = 32'h55AA33CC;
    do_reset(1'b0, 6'd16);
    strobe_to(8'h18);
    cmp("R6 grp3 ignored", 32'(grp_tag), 0);
    cmp("R6 bus kept", 32'(af_bus), 32'hCC);
    strobe_to(8'h10);
    cmp("R6 grp2 ignored", 32'(grp_tag), 0);
    strobe_to(8'h08);
    cmp("R5 grp1 loaded", 32'(grp_tag), 1);
    cmp("R7 grp1 bus", 32'(af_bus), 32'h33);
    strobe_to(8'h10);
    cmp("R6 grp2 ignored again", 32'(grp_tag), 1);
    @(negedge clk); af_strobe = 1'b0;

    // R8: dedicated lines, 5 queues strobed
    af_vec = 32'hFFFFFFFF;
    do_reset(1'b0, 6'd5);
    #1;
    cmp("R8 q5 bus", 32'(af_bus), 32'h1F);
    strobe_to(8'h08);
    cmp("R8 q5 tag fixed", 32'(grp_tag), 0);
    cmp("R8 q5 bus fixed", 32'(af_bus), 32'h1F);
    @(negedge clk); af_strobe = 1'b0;

    // R8: dedicated lines, 8 queues cycling
    af_vec = 32'hFFFF00A5;
    do_reset(1'b1, 6'd8);
    for (int e = 0; e < 3; e++) begin
      step();
      cmp("R8 q8 tag", 32'(grp_tag), 0);
      cmp("R8 q8 bus", 32'(af_bus), 32'hA5);
    end

    // R9: zero queues, and 9 queues -> 2 groups
    af_vec = 32'hFFFFFFFF;
    do_reset(1'b1, 6'd0);
    step();
    cmp("R9 q0 tag", 32'(grp_tag), 0);
    cmp("R9 q0 bus", 32'(af_bus), 0);
    do_reset(1'b1, 6'd9);
    step(); cmp("R9 q9 tag", 32'(grp_tag), 1); cmp("R9 q9 bus", 32'(af_bus), 32'h01);
    step(); cmp("R9 q9 wrap", 32'(grp_tag), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule